// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block lets an external master borrow the multiplexed address/data bus of a small controller's external memory port. It produces its own output clock, which toggles on every input clock edge. It looks at the active-low hold request only at the edges that end the low phase of that clock (a "tick"). On an accepted request it first lets any running bus cycle finish. It then stops driving the address/data lines, moves the strobe and address-valid drivers to weak inactive drive, and on the following tick pulls the active-low hold acknowledge low.

While the hold lasts, the block can lower an active-low bus request to ask for the bus back when the core has an external access waiting. When the external master removes its request, the acknowledge rises first. The bus and strobes return to strong drive one tick later, so the two masters never overlap. The bus request is cleared on the tick after that.

Top module: `bus_hold_ctrl`

## Requirements
- R1: During and right after reset: clkout=1, hold_ack_n=1, bus_req_n=1, ad_oe=1, ctl_weak=0, adv_weak=0.
- R2: clkout inverts on every clk rising edge. A tick is a rising edge at which clkout was 0. hold_ack_n, bus_req_n, ad_oe, ctl_weak and adv_weak change only at ticks.
- R3: With no bus cycle running, hold_req_n=0 at a tick sets ad_oe=0 and ctl_weak=adv_weak=1 at that tick. hold_ack_n goes to 0 at the next tick if the request is still low then. hold_ack_n is never 0 while ad_oe is 1.
- R4: While cyc_busy=1 at a tick with a pending request, ad_oe stays 1 and hold_ack_n stays 1. The first tick that sees cyc_busy=0 floats the bus, and the tick after that acknowledges.
- R5: During hold, core_pending=1 at a tick sets bus_req_n=0 at that tick. bus_req_n falls only while hold_ack_n is 0. With core_pending=0 throughout, bus_req_n stays 1.
- R6: hold_req_n=1 at a tick during hold sets hold_ack_n=1 at that tick. ad_oe returns to 1 and both weak indicators return to 0 one tick later. A low bus_req_n returns to 1 one tick after that.
- R7: If the request is withdrawn before it is acknowledged (while waiting for a cycle or while floated), the block returns to strong drive without ever lowering hold_ack_n.
- R8: A low level on hold_req_n that is gone before the next tick is ignored: hold_ack_n and ad_oe do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req_n | input | 1 | Active-low hold request from the external master |
| cyc_busy | input | 1 | A bus cycle of the device is in progress |
| core_pending | input | 1 | Core has an external access waiting |
| clkout | output | 1 | Output clock, half the input rate |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| bus_req_n | output | 1 | Active-low request to get the bus back |
| ad_oe | output | 1 | Address/data output enable (0 = floated) |
| ctl_weak | output | 1 | Strobe group (latch enable, read, write, byte-high, fetch flag) held weakly inactive |
| adv_weak | output | 1 | Address-valid strobe held weakly inactive |

## Verification
The main handshake is swept over bus-cycle lengths of zero to three ticks, over core_pending on and off, and over hold lengths of one to three ticks. The cycle-length sweep distinguishes an immediate release from a release that waits for the cycle to finish. core_pending separates a hold that raises a bus request from one that stays quiet, and the hold length shows that the release order holds however long the hold lasts. Separate patterns withdraw the request while waiting or while floated, and pulse it only during the high phase of clkout.

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic cyc_busy,
  input  logic core_pending,
  output logic clkout,
  output logic hold_ack_n,
  output logic bus_req_n,
  output logic ad_oe,
  output logic ctl_weak,
  output logic adv_weak
);

  typedef enum logic [2:0] {S_RUN, S_DRAIN, S_FLOAT, S_HOLD, S_REL} st_t;

  st_t  st, nxt;
  logic tick;

  assign tick = ~clkout;

  always_comb begin
    nxt = st;
    case (st)
      S_RUN:   if (!hold_req_n) nxt = cyc_busy ? S_DRAIN : S_FLOAT;
      S_DRAIN: if (hold_req_n) nxt = S_RUN;
               else if (!cyc_busy) nxt = S_FLOAT;
      S_FLOAT: nxt = hold_req_n ? S_RUN : S_HOLD;
      S_HOLD:  if (hold_req_n) nxt = S_REL;
      S_REL:   nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkout    <= 1'b1;
      st        <= S_RUN;
      bus_req_n <= 1'b1;
    end else begin
      clkout <= ~clkout;
      if (tick) begin
        st <= nxt;
        if (st == S_HOLD && core_pending) bus_req_n <= 1'b0;
        else if (st == S_RUN)             bus_req_n <= 1'b1;
      end
    end
  end

  assign hold_ack_n = (st != S_HOLD);
  assign ad_oe      = (st == S_RUN) || (st == S_DRAIN);
  assign ctl_weak   = (st == S_FLOAT) || (st == S_HOLD) || (st == S_REL);
  assign adv_weak   = ctl_weak;

  AST_ACK_FLOATED: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> !ad_oe);  // R3
  AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    clkout |=> $stable({hold_ack_n, bus_req_n, ad_oe, ctl_weak, adv_weak}));  // R2
  AST_FLOAT_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(!ad_oe));  // R3
  AST_BREQ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_n) |-> $past(!hold_ack_n));  // R5
  AST_GAP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> (hold_ack_n && $past(hold_ack_n, 2)));  // R6
  AST_WEAK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (ctl_weak && adv_weak));  // R3

endmodule

// File: tb/bus_hold_ctrl_tb.sv
module bus_hold_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req_n = 1'b1, cyc_busy = 1'b0, core_pending = 1'b0;
  logic clkout, hold_ack_n, bus_req_n, ad_oe, ctl_weak, adv_weak;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_hold_ctrl u_dut (.clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n),
    .cyc_busy(cyc_busy), .core_pending(core_pending), .clkout(clkout),
    .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n), .ad_oe(ad_oe),
    .ctl_weak(ctl_weak), .adv_weak(adv_weak));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (clkout) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clkout", clkout, 1'b1);
    chk("R1 ack", hold_ack_n, 1'b1);
    chk("R1 breq", bus_req_n, 1'b1);
    chk("R1 oe", ad_oe, 1'b1);
    chk("R1 weak", ctl_weak | adv_weak, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 clkout toggles", clkout, 1'b0);
    @(negedge clk);
    chk("R2 clkout toggles back", clkout, 1'b1);

    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 2; p++)
        for (int h = 1; h < 4; h++) begin
          hold_req_n = 1'b0;
          cyc_busy = (b > 0);
          for (int k = 0; k < b; k++) begin
            tick();
            chk("R4 oe while busy", ad_oe, 1'b1);
            chk("R4 no ack while busy", hold_ack_n, 1'b1);
            if (k == b - 1) cyc_busy = 1'b0;
          end
          tick();
          chk("R3 floated", ad_oe, 1'b0);
          chk("R3 ctl weak", ctl_weak, 1'b1);
          chk("R3 adv weak", adv_weak, 1'b1);
          chk("R3 ack after float", hold_ack_n, 1'b1);
          tick();
          chk("R3 ack low", hold_ack_n, 1'b0);
          core_pending = p[0];
          tick();
          chk("R5 breq", bus_req_n, ~p[0]);
          for (int k = 1; k < h; k++) begin
            tick();
            chk("R5 hold kept", hold_ack_n, 1'b0);
          end
          core_pending = 1'b0;
          hold_req_n = 1'b1;
          tick();
          chk("R6 ack released", hold_ack_n, 1'b1);
          chk("R6 bus still floated", ad_oe, 1'b0);
          tick();
          chk("R6 oe back", ad_oe, 1'b1);
          chk("R6 weak cleared", ctl_weak | adv_weak, 1'b0);
          chk("R6 breq kept", bus_req_n, ~p[0]);
          tick();
          chk("R6 breq cleared", bus_req_n, 1'b1);
        end

    hold_req_n = 1'b0; cyc_busy = 1'b1;
    tick();
    hold_req_n = 1'b1;
    tick();
    chk("R7 withdraw while busy oe", ad_oe, 1'b1);
    chk("R7 withdraw while busy ack", hold_ack_n, 1'b1);
    cyc_busy = 1'b0;
    hold_req_n = 1'b0;
    tick();
    chk("R7 floated", ad_oe, 1'b0);
    hold_req_n = 1'b1;
    tick();
    chk("R7 no ack", hold_ack_n, 1'b1);
    chk("R7 oe back", ad_oe, 1'b1);
    chk("R7 weak off", ctl_weak, 1'b0);

    tick();
    hold_req_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    hold_req_n = 1'b1;
    tick();
    chk("R8 oe unchanged", ad_oe, 1'b1);
    tick();
    chk("R8 ack unchanged", hold_ack_n, 1'b1);

    finish_run();
  end
endmodule